// File: doc/BRIEF.md
# AXI4-Lite to APB Bridge

This block is a memory-mapped slave on an AXI4-Lite link. It turns each accepted access into exactly one APB transfer. The write address and the write data arrive on separate channels and may come in either order, so each is held in its own register until its partner arrives. A complete write, or a read address, becomes a protocol-neutral request of address, direction, data and byte strobes. That request is frozen for the whole downstream transfer.

A single transfer engine runs the APB setup and access phases from the frozen request and waits in the access phase for the completer. It then returns the outcome on the write-response channel or the read-data channel. The completer's error flag is folded into the response code. Only one access is ever in flight. All three request-channel ready lines stay low from launch until the response has been taken. When a finished write and a read are waiting at the same time, the engine alternates between the two directions.

Top module: `axil_apb_bridge`

## Requirements
- R1: After reset, awready, wready and arready are 1, while psel, penable, bvalid and rvalid are 0.
- R2: A write launches only once both its AW and W handshakes have happened, in either order or in the same cycle. psel stays 0 while only one of them has been taken. The APB address is the awaddr of the AW handshake.
- R3: Every APB transfer spends exactly one cycle with psel=1, penable=0, then keeps psel=1, penable=1 until the cycle with pready=1. A new transfer never starts before the previous response has been taken.
- R4: paddr, pwrite, pwdata and pstrb hold constant from the setup cycle up to and including the completing cycle.
- R5: A write drives pwrite=1, pwdata equal to wdata and pstrb equal to wstrb, bit for bit. A read drives pwrite=0 and pstrb=0.
- R6: awready, wready and arready are 0 whenever psel, bvalid or rvalid is 1.
- R7: In the cycle after a write completes on APB, bvalid is 1 and bresp is 2'b10 if pslverr was 1 at completion, otherwise 2'b00.
- R8: In the cycle after a read completes on APB, rvalid is 1, rdata equals prdata at completion, and rresp is 2'b10 if pslverr was 1, otherwise 2'b00.
- R9: bvalid and rvalid are never 1 together. Each stays 1, with its payload unchanged, until the cycle in which bready or rready is 1.
- R10: When a complete write and a read are both waiting to launch, the direction opposite the most recently launched transfer goes first. A write goes first if no transfer has launched since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| awvalid | input | 1 | Write address valid |
| awaddr | input | ADDR_W | Write address |
| awready | output | 1 | Write address accepted |
| wvalid | input | 1 | Write data valid |
| wdata | input | DATA_W | Write data |
| wstrb | input | DATA_W/8 | Write byte enables |
| wready | output | 1 | Write data accepted |
| bvalid | output | 1 | Write response valid |
| bresp | output | 2 | Write response code |
| bready | input | 1 | Write response taken |
| arvalid | input | 1 | Read address valid |
| araddr | input | ADDR_W | Read address |
| arready | output | 1 | Read address accepted |
| rvalid | output | 1 | Read data valid |
| rdata | output | DATA_W | Read data |
| rresp | output | 2 | Read response code |
| rready | input | 1 | Read data taken |
| psel | output | 1 | APB select |
| penable | output | 1 | APB access phase |
| pwrite | output | 1 | APB direction, 1 = write |
| paddr | output | ADDR_W | APB address |
| pwdata | output | DATA_W | APB write data |
| pstrb | output | DATA_W/8 | APB byte strobes |
| pready | input | 1 | APB completer ready |
| prdata | input | DATA_W | APB read data |
| pslverr | input | 1 | APB completer error |

## Verification
Two functions can fall in the same idle cycle: completing a write request and accepting a read address. Both then compete for the one transfer engine. The bench provokes this by presenting AW, W and AR on the same clock edge, once after a read and once after a write. It judges the outcome by the order of directions seen on the APB side, which must follow the alternation rule. A full sweep over all strobe patterns, three wait-state counts, three AW/W arrival orders and both response codes covers the data path and the response mapping around it.

// File: rtl/axil_apb_pkg.sv
package axil_apb_pkg;
    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2,
        ST_RESP   = 2'd3
    } xfer_state_e;
endpackage

// File: rtl/axil_apb_wcap.sv
// Holds the write address and the write data independently until both exist.
module axil_apb_wcap #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              awvalid_i,
    input  logic [ADDR_W-1:0] awaddr_i,
    output logic              awready_o,
    input  logic              wvalid_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [STRB_W-1:0] wstrb_i,
    output logic              wready_o,
    input  logic              take_i,
    output logic              full_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic [STRB_W-1:0] strb_o
);
    typedef struct packed {
        logic              a_vld;
        logic [ADDR_W-1:0] addr;
        logic              d_vld;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
    } wcap_t;

    wcap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (take_i) begin
            cap_d.a_vld = 1'b0;
            cap_d.d_vld = 1'b0;
        end
        if (awvalid_i && awready_o) begin
            cap_d.a_vld = 1'b1;
            cap_d.addr  = awaddr_i;
        end
        if (wvalid_i && wready_o) begin
            cap_d.d_vld = 1'b1;
            cap_d.data  = wdata_i;
            cap_d.strb  = wstrb_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign awready_o = accept_i && !cap_q.a_vld;
    assign wready_o  = accept_i && !cap_q.d_vld;
    assign full_o    = cap_q.a_vld && cap_q.d_vld;
    assign addr_o    = cap_q.addr;
    assign data_o    = cap_q.data;
    assign strb_o    = cap_q.strb;
endmodule

// File: rtl/axil_apb_rcap.sv
// Holds one read address until the engine launches it.
module axil_apb_rcap #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              arvalid_i,
    input  logic [ADDR_W-1:0] araddr_i,
    output logic              arready_o,
    input  logic              take_i,
    output logic              full_o,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } rcap_t;

    rcap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (take_i) cap_d.vld = 1'b0;
        if (arvalid_i && arready_o) begin
            cap_d.vld  = 1'b1;
            cap_d.addr = araddr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign arready_o = accept_i && !cap_q.vld;
    assign full_o    = cap_q.vld;
    assign addr_o    = cap_q.addr;
endmodule

// File: rtl/axil_apb_xfer.sv
// Arbitration, frozen request, APB phase sequencing and response return.
module axil_apb_xfer
    import axil_apb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_full_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [STRB_W-1:0] wr_strb_i,
    input  logic              rd_full_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              wr_take_o,
    output logic              rd_take_o,
    output logic              idle_o,
    output logic              psel_o,
    output logic              penable_o,
    output logic              pwrite_o,
    output logic [ADDR_W-1:0] paddr_o,
    output logic [DATA_W-1:0] pwdata_o,
    output logic [STRB_W-1:0] pstrb_o,
    input  logic              pready_i,
    input  logic [DATA_W-1:0] prdata_i,
    input  logic              pslverr_i,
    output logic              bvalid_o,
    output logic [1:0]        bresp_o,
    input  logic              bready_i,
    output logic              rvalid_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [1:0]        rresp_o,
    input  logic              rready_i
);
    typedef struct packed {
        xfer_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [STRB_W-1:0] wstrb;
        logic              last_wr;
        logic [1:0]        resp;
        logic [DATA_W-1:0] rdata;
    } xfer_t;

    xfer_t x_d, x_q;
    logic  pick_wr;

    always_comb begin
        x_d       = x_q;
        wr_take_o = 1'b0;
        rd_take_o = 1'b0;
        // Write wins unless a read also waits and the last launch was a write.
        pick_wr   = wr_full_i && !(rd_full_i && x_q.last_wr);
        unique case (x_q.st)
            ST_IDLE: begin
                if (wr_full_i || rd_full_i) begin
                    x_d.st      = ST_SETUP;
                    x_d.last_wr = pick_wr;
                    x_d.write   = pick_wr;
                    if (pick_wr) begin
                        x_d.addr  = wr_addr_i;
                        x_d.wdata = wr_data_i;
                        x_d.wstrb = wr_strb_i;
                        wr_take_o = 1'b1;
                    end else begin
                        x_d.addr  = rd_addr_i;
                        x_d.wdata = '0;
                        x_d.wstrb = '0;
                        rd_take_o = 1'b1;
                    end
                end
            end
            ST_SETUP: x_d.st = ST_ACCESS;
            ST_ACCESS: begin
                if (pready_i) begin
                    x_d.st    = ST_RESP;
                    x_d.resp  = pslverr_i ? RESP_SLVERR : RESP_OKAY;
                    x_d.rdata = x_q.write ? '0 : prdata_i;
                end
            end
            ST_RESP: begin
                if (x_q.write ? bready_i : rready_i) x_d.st = ST_IDLE;
            end
            default: x_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) x_q <= '0;
        else        x_q <= x_d;
    end

    assign idle_o    = (x_q.st == ST_IDLE);
    assign psel_o    = (x_q.st == ST_SETUP) || (x_q.st == ST_ACCESS);
    assign penable_o = (x_q.st == ST_ACCESS);
    assign pwrite_o  = x_q.write;
    assign paddr_o   = x_q.addr;
    assign pwdata_o  = x_q.wdata;
    assign pstrb_o   = x_q.wstrb;
    assign bvalid_o  = (x_q.st == ST_RESP) && x_q.write;
    assign rvalid_o  = (x_q.st == ST_RESP) && !x_q.write;
    assign bresp_o   = x_q.resp;
    assign rresp_o   = x_q.resp;
    assign rdata_o   = x_q.rdata;
endmodule

// File: rtl/axil_apb_bridge.sv
module axil_apb_bridge #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    input  logic [ADDR_W-1:0] awaddr,
    output logic              awready,
    input  logic              wvalid,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    output logic              wready,
    output logic              bvalid,
    output logic [1:0]        bresp,
    input  logic              bready,
    input  logic              arvalid,
    input  logic [ADDR_W-1:0] araddr,
    output logic              arready,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    input  logic              rready,
    output logic              psel,
    output logic              penable,
    output logic              pwrite,
    output logic [ADDR_W-1:0] paddr,
    output logic [DATA_W-1:0] pwdata,
    output logic [STRB_W-1:0] pstrb,
    input  logic              pready,
    input  logic [DATA_W-1:0] prdata,
    input  logic              pslverr
);
    logic              idle;
    logic              wr_full, rd_full, wr_take, rd_take;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data;
    logic [STRB_W-1:0] wr_strb;

    axil_apb_wcap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wcap (
        .clk(clk), .rst_n(rst_n), .accept_i(idle),
        .awvalid_i(awvalid), .awaddr_i(awaddr), .awready_o(awready),
        .wvalid_i(wvalid), .wdata_i(wdata), .wstrb_i(wstrb), .wready_o(wready),
        .take_i(wr_take), .full_o(wr_full),
        .addr_o(wr_addr), .data_o(wr_data), .strb_o(wr_strb)
    );

    axil_apb_rcap #(.ADDR_W(ADDR_W)) u_rcap (
        .clk(clk), .rst_n(rst_n), .accept_i(idle),
        .arvalid_i(arvalid), .araddr_i(araddr), .arready_o(arready),
        .take_i(rd_take), .full_o(rd_full), .addr_o(rd_addr)
    );

    axil_apb_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
        .clk(clk), .rst_n(rst_n),
        .wr_full_i(wr_full), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_strb_i(wr_strb),
        .rd_full_i(rd_full), .rd_addr_i(rd_addr),
        .wr_take_o(wr_take), .rd_take_o(rd_take), .idle_o(idle),
        .psel_o(psel), .penable_o(penable), .pwrite_o(pwrite),
        .paddr_o(paddr), .pwdata_o(pwdata), .pstrb_o(pstrb),
        .pready_i(pready), .prdata_i(prdata), .pslverr_i(pslverr),
        .bvalid_o(bvalid), .bresp_o(bresp), .bready_i(bready),
        .rvalid_o(rvalid), .rdata_o(rdata), .rresp_o(rresp), .rready_i(rready)
    );
endmodule

// File: rtl/axil_apb_bridge_chk.sv
module axil_apb_bridge_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              awready,
    input logic              wready,
    input logic              arready,
    input logic              bvalid,
    input logic [1:0]        bresp,
    input logic              bready,
    input logic              rvalid,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        rresp,
    input logic              rready,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] pwdata,
    input logic [STRB_W-1:0] pstrb,
    input logic              pready,
    input logic [DATA_W-1:0] prdata,
    input logic              pslverr
);
    assert_setup_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !penable) |=> (psel && penable));

    assert_access_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        penable |-> psel);

    assert_req_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pready) |=>
            ($stable(paddr) && $stable(pwrite) && $stable(pwdata) && $stable(pstrb)));

    assert_read_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite) |-> (pstrb == '0));

    assert_ready_low_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (psel || bvalid || rvalid) |-> !(awready || wready || arready));

    assert_write_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pready && pwrite) |=>
            (bvalid && (bresp == ($past(pslverr) ? 2'b10 : 2'b00))));

    assert_read_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pready && !pwrite) |=>
            (rvalid && rdata == $past(prdata) && (rresp == ($past(pslverr) ? 2'b10 : 2'b00))));

    assert_one_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bvalid && rvalid));

    assert_b_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> (bvalid && $stable(bresp)));

    assert_r_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata) && $stable(rresp)));
endmodule

bind axil_apb_bridge axil_apb_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .awready(awready), .wready(wready), .arready(arready),
    .bvalid(bvalid), .bresp(bresp), .bready(bready),
    .rvalid(rvalid), .rdata(rdata), .rresp(rresp), .rready(rready),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
    .pready(pready), .prdata(prdata), .pslverr(pslverr)
);

// File: tb/axil_apb_bridge_tb.sv
`timescale 1ns/1ps
module axil_apb_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        awvalid = 0, wvalid = 0, arvalid = 0, bready = 0, rready = 0;
    logic [15:0] awaddr = '0, araddr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, arready, bvalid, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic        psel, penable, pwrite, pready, pslverr;
    logic [15:0] paddr;
    logic [31:0] pwdata, prdata;
    logic [3:0]  pstrb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    axil_apb_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .awvalid(awvalid), .awaddr(awaddr), .awready(awready),
        .wvalid(wvalid), .wdata(wdata), .wstrb(wstrb), .wready(wready),
        .bvalid(bvalid), .bresp(bresp), .bready(bready),
        .arvalid(arvalid), .araddr(araddr), .arready(arready),
        .rvalid(rvalid), .rdata(rdata), .rresp(rresp), .rready(rready),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
        .pready(pready), .prdata(prdata), .pslverr(pslverr)
    );

    // APB completer model: wait_n extra access cycles, error on address nibble E.
    int       wait_n = 0;
    logic [3:0] acc_cnt;
    always @(posedge clk) begin
        if (!rst_n)                         acc_cnt <= '0;
        else if (psel && penable && !pready) acc_cnt <= acc_cnt + 4'd1;
        else                                 acc_cnt <= '0;
    end
    assign pready  = psel && penable && (acc_cnt == wait_n[3:0]);
    assign pslverr = pready && (paddr[15:12] == 4'hE);
    assign prdata  = {~paddr, paddr};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // APB monitor, sampled at the falling edge.
    int          n_xfer = 0;
    logic [15:0] m_addr;
    logic        m_wr;
    logic [31:0] m_data;
    logic [3:0]  m_strb;
    logic [1:0]  hist = '0;
    bit          prev_setup = 0;
    logic [15:0] s_addr;
    logic [31:0] s_data;
    logic [3:0]  s_strb;
    always @(negedge clk) begin
        if (rst_n) begin
            if (psel)
                chk(!awready && !wready && !arready, "R6 ready low during transfer",
                    {29'd0, awready, wready, arready}, 32'd0);
            if (prev_setup)
                chk(psel && penable, "R3 access follows setup", {30'd0, psel, penable}, 32'd3);
            if (psel && !penable) begin
                s_addr = paddr; s_data = pwdata; s_strb = pstrb;
            end
            if (psel && penable)
                chk(paddr == s_addr && pwdata == s_data && pstrb == s_strb,
                    "R4 request frozen", {16'd0, paddr}, {16'd0, s_addr});
            prev_setup = psel && !penable;
            if (psel && penable && pready) begin
                n_xfer++;
                m_addr = paddr; m_wr = pwrite; m_data = pwdata; m_strb = pstrb;
                hist = {hist[0], pwrite};
            end
        end
    end

    task automatic send_aw(input logic [15:0] a);
        awaddr = a; awvalid = 1'b1;
        while (!awready) @(negedge clk);
        @(negedge clk); awvalid = 1'b0;
    endtask

    task automatic send_w(input logic [31:0] d, input logic [3:0] s);
        wdata = d; wstrb = s; wvalid = 1'b1;
        while (!wready) @(negedge clk);
        @(negedge clk); wvalid = 1'b0;
    endtask

    task automatic send_ar(input logic [15:0] a);
        araddr = a; arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk); arvalid = 1'b0;
    endtask

    task automatic idle_gap(input string req);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!psel, req, {31'd0, psel}, 32'd0);
        end
    endtask

    task automatic wait_resp(input bit is_wr, input logic [1:0] exp_resp,
                             input logic [31:0] exp_rd, input bit hold);
        int t = 0;
        while (!(is_wr ? bvalid : rvalid) && t < 100) begin @(negedge clk); t++; end
        if (is_wr) chk(bvalid && bresp == exp_resp, "R7 write response", {30'd0, bresp}, {30'd0, exp_resp});
        else begin
            chk(rvalid && rresp == exp_resp, "R8 read response code", {30'd0, rresp}, {30'd0, exp_resp});
            chk(rdata == exp_rd, "R8 read data", rdata, exp_rd);
        end
        if (hold) begin
            for (int i = 0; i < 2; i++) begin
                @(negedge clk);
                chk(is_wr ? bvalid : rvalid, "R9 response held", 32'd0, 32'd1);
                chk(!bvalid || !rvalid, "R9 single response", {30'd0, bvalid, rvalid}, 32'd0);
                chk(!awready && !wready && !arready, "R6 ready low while response pending",
                    {29'd0, awready, wready, arready}, 32'd0);
            end
        end
        if (is_wr) bready = 1'b1; else rready = 1'b1;
        @(negedge clk);
        bready = 1'b0; rready = 1'b0;
        chk(!bvalid && !rvalid, "R9 response drops after ready", {30'd0, bvalid, rvalid}, 32'd0);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] s,
                            input int order, input int wt, input bit hold);
        int base = n_xfer;
        wait_n = wt;
        case (order)
            0: fork send_aw(a); send_w(d, s); join
            1: begin send_aw(a); idle_gap("R2 no launch with address only"); send_w(d, s); end
            default: begin send_w(d, s); idle_gap("R2 no launch with data only"); send_aw(a); end
        endcase
        wait_resp(1'b1, (a[15:12] == 4'hE) ? 2'b10 : 2'b00, 32'd0, hold);
        chk(n_xfer == base + 1, "R3 exactly one transfer", n_xfer, base + 1);
        chk(m_wr && m_addr == a, "R2 write address", {16'd0, m_addr}, {16'd0, a});
        chk(m_data == d, "R5 pwdata", m_data, d);
        chk(m_strb == s, "R5 pstrb", {28'd0, m_strb}, {28'd0, s});
    endtask

    task automatic do_read(input logic [15:0] a, input int wt, input bit hold);
        int base = n_xfer;
        wait_n = wt;
        send_ar(a);
        wait_resp(1'b0, (a[15:12] == 4'hE) ? 2'b10 : 2'b00, {~a, a}, hold);
        chk(n_xfer == base + 1, "R3 exactly one transfer", n_xfer, base + 1);
        chk(!m_wr && m_addr == a && m_strb == 4'd0, "R5 read direction and strobe",
            {11'd0, m_wr, m_strb, m_addr}, {16'd0, a});
    endtask

    task automatic collide(input logic [1:0] exp_hist, input string req);
        int base = n_xfer;
        int t = 0;
        bready = 1'b1; rready = 1'b1; wait_n = 0;
        fork send_aw(16'h2040); send_w(32'hCAFE_F00D, 4'hF); send_ar(16'h2080); join
        while (n_xfer < base + 2 && t < 100) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        chk(n_xfer == base + 2, {req, " both served"}, n_xfer, base + 2);
        chk(hist == exp_hist, req, {30'd0, hist}, {30'd0, exp_hist});
        bready = 1'b0; rready = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(awready && wready && arready, "R1 readies after reset", {29'd0, awready, wready, arready}, 32'd7);
        chk(!psel && !penable && !bvalid && !rvalid, "R1 idle outputs after reset",
            {28'd0, psel, penable, bvalid, rvalid}, 32'd0);

        // R10: first collision after reset, nothing launched yet -> write first.
        collide(2'b10, "R10 write first from reset");

        for (int s = 0; s < 16; s++) begin
            for (int wt = 0; wt < 3; wt++) begin
                logic [15:0] a;
                logic [31:0] d;
                a = {((s % 5) == 0) ? 4'hE : 4'h3, 4'(wt), 4'(s), 4'h4};
                d = 32'h9E37_79B9 * (s * 3 + wt + 1);
                do_write(a, d, 4'(s), (s + wt) % 3, wt, wt == 1);
                do_read(a ^ 16'h0008, 2 - wt, wt == 2);
            end
        end

        // R10: after a read, write goes first; after a write, read goes first.
        do_read(16'h3000, 0, 1'b0);
        collide(2'b10, "R10 write after read");
        do_write(16'h3010, 32'h0000_00A5, 4'b0010, 0, 0, 1'b0);
        collide(2'b01, "R10 read after write");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule